// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block holds the program counter of a simple in-order core and decides, every clock, where the next fetch goes. It decodes the instruction word presented at its input and recognises the whole conditional-branch and jump family of a 32-bit load/store instruction set: register-compare branches, sign tests against zero, pseudo-direct jumps and register-indirect jumps. For call-type jumps it also produces the write of the return address into the register file.

The register-file read values for the rs and rt fields come in beside the instruction. The next PC, the link write and an invalid-encoding flag are combinational outputs. The internal PC register takes the next PC on every rising clock edge. An instruction that is not a control transfer simply advances the PC by one word. A control-transfer encoding with a malformed sub-field is flagged and also just advances.

Top module: `flow_redirect_unit`

## Requirements
- R1: A synchronous active-high `rst` loads `pc_q` with the parameter `RESET_PC` (default 32'hBFC0_0000). Outside reset, `pc_q` takes the value `next_pc` had in the previous cycle, at every rising edge.
- R2: Any instruction whose opcode (bits 31..26) is not one of the control-transfer opcodes gives `next_pc = pc_q + 4`, `link_we = 0` and `illegal = 0`. The same holds for opcode 000000 with a function field (bits 5..0) other than 001000 or 001001.
- R3: Opcode 000100 (equal) and opcode 000101 (not equal) compare `rs_val` with `rt_val`. When taken, the target is `pc_q + 4` plus the 16-bit immediate (bits 15..0), sign-extended and shifted left by 2. When not taken, the target is `pc_q + 4`.
- R4: Opcode 000110 branches when `rs_val` is less than or equal to zero. Opcode 000111 branches when it is greater than zero. Both treat `rs_val` as signed 32-bit and use the R3 target. Both require the rt field (bits 20..16) to be 00000; otherwise the encoding is invalid.
- R5: Opcode 000001 uses the rt field as a sub-function. 00000 branches when `rs_val` is below zero, and 00001 branches when it is zero or above, with the R3 target. Any other rt value is invalid.
- R6: Opcodes 000010 (jump) and 000011 (jump-and-link) go to {(pc_q+4)[31:28], bits 25..0, 2'b00}.
- R7: Opcode 000011 raises `link_we` with `link_idx = 31` and `link_val = pc_q + 4`.
- R8: Opcode 000000 with function 001000 loads `next_pc` with `rs_val` and never writes a link. The rt, rd and shamt fields (bits 20..16, 15..11, 10..6) must all be zero; otherwise the encoding is invalid.
- R9: Opcode 000000 with function 001001 loads `next_pc` with `rs_val` and writes `pc_q + 4` to the register named by bits 15..11. The rt and shamt fields must be zero; otherwise the encoding is invalid.
- R10: A link write aimed at register 0 is dropped (`link_we = 0`), and the jump itself still takes place.
- R11: An invalid encoding raises `illegal`, gives `next_pc = pc_q + 4` and keeps `link_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | Register value selected by bits 25..21 |
| rt_val | input | 32 | Register value selected by bits 20..16 |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | PC loaded at the next edge |
| link_we | output | 1 | Return-address write enable |
| link_idx | output | 5 | Destination register of the return address |
| link_val | output | 32 | Return address (pc_q + 4) |
| illegal | output | 1 | Malformed control-transfer encoding |

## Verification
Every branch kind is driven on both sides of its condition. The register values are picked around zero and around the sign bit (0, 1, all ones, 0x8000_0000), so that a signed test that has turned unsigned, or a flipped strict/non-strict bound, lands on the wrong target. Immediates of +1, -2, -4, 0x7FFF and 0x8000 separate a missing sign extension or shift from a correct one at both reach limits. A jump placed where PC+4 crosses a 256 MB boundary shows whether the upper bits come from PC or from PC+4. Malformed sub-fields sit on encodings that would otherwise be taken, and a link to register 0 shows that the write is dropped while the jump still happens.

// File: rtl/flow_pkg.sv
package flow_pkg;
    localparam int XLEN  = 32;
    localparam int RIDX  = 5;
    localparam int OPW   = 6;
    localparam int IMMW  = 16;
    localparam int JTW   = 26;
    localparam int INSTB = 4;   // bytes per instruction

    localparam logic [OPW-1:0] OP_SPECIAL = 6'b000000;
    localparam logic [OPW-1:0] OP_REGIMM  = 6'b000001;
    localparam logic [OPW-1:0] OP_JMP     = 6'b000010;
    localparam logic [OPW-1:0] OP_JMPL    = 6'b000011;
    localparam logic [OPW-1:0] OP_EQ      = 6'b000100;
    localparam logic [OPW-1:0] OP_NE      = 6'b000101;
    localparam logic [OPW-1:0] OP_LEZ     = 6'b000110;
    localparam logic [OPW-1:0] OP_GTZ     = 6'b000111;

    localparam logic [5:0] FN_JREG  = 6'b001000;
    localparam logic [5:0] FN_JREGL = 6'b001001;

    localparam logic [RIDX-1:0] SUB_LTZ = 5'b00000;
    localparam logic [RIDX-1:0] SUB_GEZ = 5'b00001;
    localparam logic [RIDX-1:0] RA_IDX  = 5'd31;

    typedef enum logic [3:0] {
        XK_SEQ, XK_EQ, XK_NE, XK_LEZ, XK_GTZ, XK_LTZ, XK_GEZ,
        XK_JMP, XK_JMPL, XK_JREG, XK_JREGL
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e      kind;
        logic            bad;
        logic [RIDX-1:0] link_idx;
    } xfer_dec_t;

    function automatic logic [XLEN-1:0] branch_offset(input logic [IMMW-1:0] imm);
        return {{(XLEN-IMMW-2){imm[IMMW-1]}}, imm, 2'b00};
    endfunction

    function automatic logic is_call(input xfer_kind_e k);
        return (k == XK_JMPL) || (k == XK_JREGL);
    endfunction
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
    import flow_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output xfer_dec_t       dec
);
    logic [OPW-1:0]  op;
    logic [RIDX-1:0] f_rt, f_rd, f_sh;
    logic [5:0]      fn;

    assign op   = instr[31:26];
    assign f_rt = instr[20:16];
    assign f_rd = instr[15:11];
    assign f_sh = instr[10:6];
    assign fn   = instr[5:0];

    always_comb begin
        dec.kind     = XK_SEQ;
        dec.bad      = 1'b0;
        dec.link_idx = RA_IDX;
        unique case (op)
            OP_SPECIAL: begin
                if (fn == FN_JREG) begin
                    if (f_rt == '0 && f_rd == '0 && f_sh == '0) dec.kind = XK_JREG;
                    else                                       dec.bad  = 1'b1;
                end else if (fn == FN_JREGL) begin
                    if (f_rt == '0 && f_sh == '0) begin
                        dec.kind     = XK_JREGL;
                        dec.link_idx = f_rd;
                    end else begin
                        dec.bad = 1'b1;
                    end
                end
            end
            OP_REGIMM: begin
                if      (f_rt == SUB_LTZ) dec.kind = XK_LTZ;
                else if (f_rt == SUB_GEZ) dec.kind = XK_GEZ;
                else                      dec.bad  = 1'b1;
            end
            OP_LEZ:  if (f_rt == '0) dec.kind = XK_LEZ; else dec.bad = 1'b1;
            OP_GTZ:  if (f_rt == '0) dec.kind = XK_GTZ; else dec.bad = 1'b1;
            OP_EQ:   dec.kind = XK_EQ;
            OP_NE:   dec.kind = XK_NE;
            OP_JMP:  dec.kind = XK_JMP;
            OP_JMPL: dec.kind = XK_JMPL;
            default: dec.kind = XK_SEQ;
        endcase
    end
endmodule

// File: rtl/xfer_cond.sv
module xfer_cond
    import flow_pkg::*;
(
    input  xfer_kind_e      kind,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            taken
);
    logic neg, zero;
    assign neg  = a[XLEN-1];
    assign zero = (a == '0);

    always_comb begin
        unique case (kind)
            XK_EQ:  taken = (a == b);
            XK_NE:  taken = (a != b);
            XK_LEZ: taken = neg | zero;
            XK_GTZ: taken = !neg && !zero;
            XK_LTZ: taken = neg;
            XK_GEZ: taken = !neg;
            XK_JMP, XK_JMPL, XK_JREG, XK_JREGL: taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/xfer_target.sv
module xfer_target
    import flow_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs_val,
    input  xfer_dec_t       dec,
    input  logic            taken,
    output logic [XLEN-1:0] npc,
    output logic            lwe,
    output logic [RIDX-1:0] lidx,
    output logic [XLEN-1:0] lval
);
    logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;

    assign seq_pc = pc + XLEN'(INSTB);
    assign br_pc  = seq_pc + branch_offset(instr[IMMW-1:0]);
    assign jmp_pc = {seq_pc[XLEN-1:JTW+2], instr[JTW-1:0], 2'b00};

    always_comb begin
        npc = seq_pc;
        if (taken) begin
            unique case (dec.kind)
                XK_JREG, XK_JREGL: npc = rs_val;
                XK_JMP, XK_JMPL:   npc = jmp_pc;
                default:           npc = br_pc;
            endcase
        end
    end

    assign lwe  = is_call(dec.kind) && (dec.link_idx != '0);
    assign lidx = dec.link_idx;
    assign lval = seq_pc;
endmodule

// File: rtl/flow_redirect_unit.sv
module flow_redirect_unit
    import flow_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'hBFC0_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] next_pc,
    output logic            link_we,
    output logic [RIDX-1:0] link_idx,
    output logic [XLEN-1:0] link_val,
    output logic            illegal
);
    xfer_dec_t dec;
    logic      taken;

    xfer_decode u_dec (.instr(instr), .dec(dec));

    xfer_cond u_cond (.kind(dec.kind), .a(rs_val), .b(rt_val), .taken(taken));

    xfer_target u_tgt (
        .pc(pc_q), .instr(instr), .rs_val(rs_val), .dec(dec), .taken(taken),
        .npc(next_pc), .lwe(link_we), .lidx(link_idx), .lval(link_val)
    );

    assign illegal = dec.bad;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= next_pc;
    end

    assert_reset_pc_R1: assert property (@(posedge clk) rst |=> pc_q == RESET_PC);

    assert_pc_follows_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_q == $past(next_pc));

    assert_bad_falls_through_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (next_pc == pc_q + 32'd4) && !link_we);

    assert_no_zero_link_R10: assert property (@(posedge clk) disable iff (rst)
        link_we |-> link_idx != '0);

    assert_link_value_R7: assert property (@(posedge clk) disable iff (rst)
        link_we |-> link_val == pc_q + 32'd4);

    assert_jreg_nolink_R8: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OP_SPECIAL && instr[5:0] == FN_JREG) |-> !link_we);

    assert_plain_seq_R2: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] > OP_GTZ) |-> (next_pc == pc_q + 32'd4) && !illegal && !link_we);
endmodule

// File: tb/sim_flow_redirect_unit.sv
module sim_flow_redirect_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0, rs_val = 32'h0, rt_val = 32'h0;
    logic [31:0] pc_q, next_pc, link_val;
    logic        link_we, illegal;
    logic [4:0]  link_idx;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    localparam logic [31:0] RST_PC = 32'hBFC0_0000;

    always #5 clk = ~clk;

    flow_redirect_unit #(.RESET_PC(RST_PC)) u0 (
        .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .pc_q(pc_q), .next_pc(next_pc), .link_we(link_we), .link_idx(link_idx),
        .link_val(link_val), .illegal(illegal)
    );

    function automatic logic [31:0] ei(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] er(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [4:0] sh,
                                       input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, sh, fn};
    endfunction
    function automatic logic [31:0] ej(input logic [5:0] op, input logic [25:0] t);
        return {op, t};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] nxt;
        logic        we;
        logic [4:0]  idx;
        logic        bad;
        logic [3:0]  req;
    } row_t;

    localparam int NROW = 29;
    localparam row_t ROWS [0:NROW-1] = '{
        '{er(1,2,3,0,6'h20),          32'h0,         32'h0, 32'hBFC0_0004, 1'b0, 5'd0,  1'b0, 4'd2},  // R2 plain add
        '{er(4,0,0,0,6'h08),          32'h0000_2000, 32'h0, 32'h0000_2000, 1'b0, 5'd0,  1'b0, 4'd8},  // R8 jreg
        '{ei(6'h04,5,5,16'd3),        32'h5,         32'h5, 32'h0000_2010, 1'b0, 5'd0,  1'b0, 4'd3},  // R3 eq taken
        '{ei(6'h04,5,6,16'd3),        32'h5,         32'h6, 32'h0000_2014, 1'b0, 5'd0,  1'b0, 4'd3},  // R3 eq not
        '{ei(6'h05,1,2,16'hFFFE),     32'h1,         32'h2, 32'h0000_2010, 1'b0, 5'd0,  1'b0, 4'd3},  // R3 ne back
        '{ei(6'h05,1,2,16'hFFFE),     32'h7,         32'h7, 32'h0000_2014, 1'b0, 5'd0,  1'b0, 4'd3},  // R3 ne not
        '{ei(6'h06,1,0,16'd4),        32'h0,         32'h0, 32'h0000_2028, 1'b0, 5'd0,  1'b0, 4'd4},  // R4 lez at 0
        '{ei(6'h07,1,0,16'd4),        32'h0,         32'h0, 32'h0000_202C, 1'b0, 5'd0,  1'b0, 4'd4},  // R4 gtz at 0
        '{ei(6'h07,1,0,16'd1),        32'h1,         32'h0, 32'h0000_2034, 1'b0, 5'd0,  1'b0, 4'd4},  // R4 gtz at 1
        '{ei(6'h06,1,0,16'hFFFC),     32'hFFFF_FFFF, 32'h0, 32'h0000_2028, 1'b0, 5'd0,  1'b0, 4'd4},  // R4 lez at -1
        '{ei(6'h07,1,0,16'd4),        32'h8000_0000, 32'h0, 32'h0000_202C, 1'b0, 5'd0,  1'b0, 4'd4},  // R4 gtz min
        '{ei(6'h01,1,0,16'd2),        32'h8000_0000, 32'h0, 32'h0000_2038, 1'b0, 5'd0,  1'b0, 4'd5},  // R5 ltz taken
        '{ei(6'h01,1,0,16'd2),        32'h0,         32'h0, 32'h0000_203C, 1'b0, 5'd0,  1'b0, 4'd5},  // R5 ltz at 0
        '{ei(6'h01,1,1,16'd1),        32'h0,         32'h0, 32'h0000_2044, 1'b0, 5'd0,  1'b0, 4'd5},  // R5 gez at 0
        '{ei(6'h01,1,1,16'd1),        32'hFFFF_FFFF, 32'h0, 32'h0000_2048, 1'b0, 5'd0,  1'b0, 4'd5},  // R5 gez at -1
        '{ei(6'h06,1,3,16'd4),        32'h0,         32'h0, 32'h0000_204C, 1'b0, 5'd0,  1'b1, 4'd4},  // R4 R11 rt!=0
        '{ei(6'h01,1,5,16'd4),        32'h8000_0000, 32'h0, 32'h0000_2050, 1'b0, 5'd0,  1'b1, 4'd5},  // R5 R11 bad sub
        '{er(4,0,7,0,6'h08),          32'h0000_9000, 32'h0, 32'h0000_2054, 1'b0, 5'd0,  1'b1, 4'd8},  // R8 R11 rd!=0
        '{ej(6'h03,26'h000_0100),     32'h0,         32'h0, 32'h0000_0400, 1'b1, 5'd31, 1'b0, 4'd7},  // R7 jal
        '{er(4,0,9,0,6'h09),          32'h7000_0010, 32'h0, 32'h7000_0010, 1'b1, 5'd9,  1'b0, 4'd9},  // R9 jregl
        '{ej(6'h02,26'h3FF_FFFF),     32'h0,         32'h0, 32'h7FFF_FFFC, 1'b0, 5'd0,  1'b0, 4'd6},  // R6 j
        '{er(4,0,0,0,6'h09),          32'h0000_3000, 32'h0, 32'h0000_3000, 1'b0, 5'd0,  1'b0, 4'd10}, // R10 link r0
        '{er(4,0,9,3,6'h09),          32'h0000_5000, 32'h0, 32'h0000_3004, 1'b0, 5'd0,  1'b1, 4'd9},  // R9 R11 shamt
        '{ei(6'h04,0,0,16'h8000),     32'h0,         32'h0, 32'hFFFE_3008, 1'b0, 5'd0,  1'b0, 4'd3},  // R3 min reach
        '{er(4,0,0,0,6'h08),          32'h0010_0000, 32'h0, 32'h0010_0000, 1'b0, 5'd0,  1'b0, 4'd8},  // R8
        '{ei(6'h04,0,0,16'h7FFF),     32'h0,         32'h0, 32'h0012_0000, 1'b0, 5'd0,  1'b0, 4'd3},  // R3 max reach
        '{er(4,0,0,0,6'h08),          32'hEFFF_FFFC, 32'h0, 32'hEFFF_FFFC, 1'b0, 5'd0,  1'b0, 4'd8},  // R8
        '{ej(6'h02,26'h0),            32'h0,         32'h0, 32'hF000_0000, 1'b0, 5'd0,  1'b0, 4'd6},  // R6 uses pc+4
        '{ei(6'h23,1,2,16'd8),        32'h0,         32'h0, 32'hF000_0004, 1'b0, 5'd0,  1'b0, 4'd2}   // R2 load
    };

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] cur;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1: reset value visible right after reset
        chk(pc_q == RST_PC, "R1 reset pc", pc_q, RST_PC);
        cur = RST_PC;
        for (int i = 0; i < NROW; i++) begin
            instr  = ROWS[i].ins;
            rs_val = ROWS[i].a;
            rt_val = ROWS[i].b;
            #1;
            chk(next_pc == ROWS[i].nxt, $sformatf("R%0d row %0d next_pc", ROWS[i].req, i), next_pc, ROWS[i].nxt);
            chk(link_we == ROWS[i].we, $sformatf("R%0d row %0d link_we", ROWS[i].req, i), 32'(link_we), 32'(ROWS[i].we));
            chk(illegal == ROWS[i].bad, $sformatf("R11 row %0d illegal", i), 32'(illegal), 32'(ROWS[i].bad));
            if (ROWS[i].we) begin
                chk(link_idx == ROWS[i].idx, $sformatf("R%0d row %0d link_idx", ROWS[i].req, i), 32'(link_idx), 32'(ROWS[i].idx));
                chk(link_val == cur + 32'd4, $sformatf("R%0d row %0d link_val", ROWS[i].req, i), link_val, cur + 32'd4);
            end
            @(posedge clk);
            #2;
            chk(pc_q == ROWS[i].nxt, $sformatf("R1 row %0d pc load", i), pc_q, ROWS[i].nxt);
            cur = ROWS[i].nxt;
        end
        // R1: reset in mid-run overrides a taken jump
        instr = er(4, 0, 0, 0, 6'h08); rs_val = 32'h1234_5678;
        rst = 1'b1;
        @(posedge clk); #2;
        chk(pc_q == RST_PC, "R1 mid-run reset", pc_q, RST_PC);
        rst = 1'b0;
        // R10: jal-style write to r0 still jumps
        instr = er(4, 0, 0, 0, 6'h09); rs_val = 32'h0000_0040; #1;
        chk(link_we == 1'b0, "R10 r0 link dropped", 32'(link_we), 32'd0);
        @(posedge clk); #2;
        chk(pc_q == 32'h0000_0040, "R10 jump still taken", pc_q, 32'h0000_0040);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule